// File: doc/BRIEF.md
# Ping-Pong Dual Multiplier Pipeline

This block is a full-rate signed multiply stage. It accepts one pair of 16-bit two's complement operands on any clock, marked by an input valid. It returns the full 32-bit signed product, marked by an output valid, a fixed number of clocks later. Neither multiplier inside has to finish in one clock. Valid operand pairs are dealt out alternately to two identical multiplier paths. Each path latches its operands on its own enable cycle and latches its product two clocks later, so the multiply logic can be constrained as a two-cycle path.

A single steering bit picks the path for each valid pair. The bit clears at reset and flips only when a valid pair arrives, so idle cycles in the stream never change which path is next. A copy of that bit, delayed to match the path timing, drives the output mux. Products therefore leave one per clock, in the order their operands arrived, with idle cycles kept in the same places.

Top module: `ppmul`

## Requirements
- R1: While reset is asserted, and for the first four rising edges after it is released, out_valid is 0.
- R2: out_prod is the signed 32-bit product of in_a and in_b, both taken as 16-bit two's complement, with no truncation or rounding.
- R3: A pair sampled with in_valid=1 on a rising edge produces out_valid=1 and its product right after the fourth rising edge that follows. A cycle with in_valid=0 produces out_valid=0 at the same distance.
- R4: Back-to-back valid pairs give back-to-back products, one per clock, in input order.
- R5: The steering bit flips on every valid pair and holds on every idle cycle. Idle gaps of any length or pattern do not reorder or drop products.
- R6: Consecutive valid pairs go to opposite paths. A path never captures operands on two consecutive clocks.
- R7: A path's operand registers hold steady from capture until its product register loads, two clocks after the capture.
- R8: The extreme operand values give exact products: -32768*-32768 = 0x40000000, -32768*32767 = -1073709056, 32767*32767 = 1073676289, and anything times 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on in_a/in_b is valid this cycle |
| in_a | input | 16 | Multiplicand, signed two's complement |
| in_b | input | 16 | Multiplier, signed two's complement |
| out_valid | output | 1 | out_prod holds a product this cycle |
| out_prod | output | 32 | Signed product |

## Verification
A steering bit that flips on an idle cycle, or fails to flip on a valid one, shows up at the ports four clocks later as a product taken from the wrong path. That wrong product is usually the one belonging to the neighbouring pair, so dense back-to-back random traffic mixed with random gaps exposes it within a few vectors. A product register that loads one clock early latches a half-settled or stale operand set and appears as a wrong value at the next output. A wrong valid delay shows as a shifted valid pattern against the gaps in the stream.

// File: rtl/ppmul_pkg.sv
package ppmul_pkg;
  // number of multiplier paths taking turns
  localparam int PP_PATHS  = 2;
  // edges from input sample to output register load
  localparam int PP_STAGES = 3;
  localparam int PP_LAT    = PP_STAGES + 1;
endpackage

// File: rtl/ppmul_steer.sv
module ppmul_steer
  import ppmul_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                tog,
  output logic [PP_PATHS-1:0] cap_en,
  output logic [PP_PATHS-1:0] done_en,
  output logic                res_valid,
  output logic                res_sel
);
  logic                 tog_q;
  logic [PP_STAGES-1:0] vpipe;
  logic [PP_STAGES-1:0] spipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      vpipe <= '0;
      spipe <= '0;
    end else begin
      if (in_valid) tog_q <= ~tog_q;
      vpipe <= {vpipe[PP_STAGES-2:0], in_valid};
      spipe <= {spipe[PP_STAGES-2:0], tog_q};
    end
  end

  for (genvar p = 0; p < PP_PATHS; p++) begin : g_en
    assign cap_en[p]  = in_valid & (tog_q == 1'(p));
    // capture happened one edge before vpipe[1] was set; load on the next edge
    assign done_en[p] = vpipe[1] & (spipe[1] == 1'(p));
  end

  assign tog       = tog_q;
  assign res_valid = vpipe[PP_STAGES-1];
  assign res_sel   = spipe[PP_STAGES-1];
endmodule

// File: rtl/ppmul_path.sv
module ppmul_path #(
  parameter int A_W = 16,
  parameter int B_W = 16,
  localparam int P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en,
  input  logic           done_en,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic [P_W-1:0] ops,
  output logic [P_W-1:0] prod
);
  logic [A_W-1:0] opa_q;
  logic [B_W-1:0] opb_q;

  function automatic logic [P_W-1:0] smul(input logic [A_W-1:0] x,
                                          input logic [B_W-1:0] y);
    logic signed [P_W-1:0] r;
    r = $signed(x) * $signed(y);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (cap_en) begin
      opa_q <= a;
      opb_q <= b;
    end
  end

  // two-cycle path: operands settle at capture, product loads two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prod <= '0;
    else if (done_en) prod <= smul(opa_q, opb_q);
  end

  assign ops = {opa_q, opb_q};
endmodule

// File: rtl/ppmul_merge.sv
module ppmul_merge
  import ppmul_pkg::*;
#(
  parameter int P_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    res_valid,
  input  logic                    res_sel,
  input  logic [PP_PATHS*P_W-1:0] prods,
  output logic                    out_valid,
  output logic [P_W-1:0]          out_prod
);
  logic [P_W-1:0] picked;
  assign picked = res_sel ? prods[P_W +: P_W] : prods[0 +: P_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= res_valid;
      if (res_valid) out_prod <= picked;
    end
  end
endmodule

// File: rtl/ppmul.sv
module ppmul
  import ppmul_pkg::*;
#(
  parameter int A_W = 16,
  parameter int B_W = 16,
  localparam int P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [A_W-1:0] in_a,
  input  logic [B_W-1:0] in_b,
  output logic           out_valid,
  output logic [P_W-1:0] out_prod
);
  logic                    tog_w;
  logic [PP_PATHS-1:0]     cap_en_w;
  logic [PP_PATHS-1:0]     done_en_w;
  logic                    res_valid_w;
  logic                    res_sel_w;
  logic [PP_PATHS*P_W-1:0] ops_w;
  logic [PP_PATHS*P_W-1:0] prods_w;

  ppmul_steer u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .tog      (tog_w),
    .cap_en   (cap_en_w),
    .done_en  (done_en_w),
    .res_valid(res_valid_w),
    .res_sel  (res_sel_w)
  );

  for (genvar p = 0; p < PP_PATHS; p++) begin : g_path
    ppmul_path #(.A_W(A_W), .B_W(B_W)) u_path (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en_w[p]),
      .done_en(done_en_w[p]),
      .a      (in_a),
      .b      (in_b),
      .ops    (ops_w[p*P_W +: P_W]),
      .prod   (prods_w[p*P_W +: P_W])
    );
  end

  ppmul_merge #(.P_W(P_W)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_valid(res_valid_w),
    .res_sel  (res_sel_w),
    .prods    (prods_w),
    .out_valid(out_valid),
    .out_prod (out_prod)
  );
endmodule

// File: rtl/ppmul_chk.sv
module ppmul_chk #(
  parameter int A_W = 16,
  parameter int B_W = 16,
  localparam int P_W = A_W + B_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [A_W-1:0]   in_a,
  input logic [B_W-1:0]   in_b,
  input logic             out_valid,
  input logic [P_W-1:0]   out_prod,
  input logic             tog,
  input logic [1:0]       cap_en,
  input logic [1:0]       done_en,
  input logic [2*P_W-1:0] ops
);
  logic [2:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen <= '0;
    else if (seen != 4) seen <= seen + 3'd1;
  end

  logic signed [P_W-1:0] ref_prod;
  assign ref_prod = $signed(in_a) * $signed(in_b);

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen < 4) |-> !out_valid);
  // R3
  lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 4) |-> (out_valid == $past(in_valid, 4)));
  // R2
  prod_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 4 && out_valid) |-> (out_prod == $past(ref_prod, 4)));
  // R5
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (tog != $past(tog)));
  // R5
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(tog));
  // R6
  one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_en));
  // R6
  gap0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en[0] |=> !cap_en[0]);
  // R6
  gap1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en[1] |=> !cap_en[1]);
  // R7
  load0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2 && done_en[0]) |-> $past(cap_en[0], 2));
  // R7
  load1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2 && done_en[1]) |-> $past(cap_en[1], 2));
  // R7
  hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en[0] |=> $stable(ops[0 +: P_W]));
  // R7
  hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en[1] |=> $stable(ops[P_W +: P_W]));
endmodule

bind ppmul ppmul_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_a     (in_a),
  .in_b     (in_b),
  .out_valid(out_valid),
  .out_prod (out_prod),
  .tog      (tog_w),
  .cap_en   (cap_en_w),
  .done_en  (done_en_w),
  .ops      (ops_w)
);

// File: tb/sim_ppmul.sv
module sim_ppmul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic        out_valid;
  logic [31:0] out_prod;

  always #4ns clk = ~clk;

  ppmul u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_prod(out_prod)
  );

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;
  string       tag = "R1";

  // expected history: index 3 is the pair applied four falling edges ago
  logic        hv[4];
  logic [31:0] hp[4];

  function automatic logic [31:0] golden(input logic [15:0] a, input logic [15:0] b);
    longint sa, sb;
    sa = (a[15]) ? longint'(a) - 65536 : longint'(a);
    sb = (b[15]) ? longint'(b) - 65536 : longint'(b);
    return 32'(sa * sb);
  endfunction

  task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    n_vec++;
    if (out_valid !== hv[3]) begin
      n_bad++;
      $display("FAIL %s out_valid actual=%b expected=%b", tag, out_valid, hv[3]);
    end else if (hv[3] && out_prod !== hp[3]) begin
      n_bad++;
      $display("FAIL %s out_prod actual=%h expected=%h", tag, out_prod, hp[3]);
    end
    for (int k = 3; k > 0; k--) begin
      hv[k] = hv[k-1];
      hp[k] = hp[k-1];
    end
    hv[0] = v && rst_n;
    hp[0] = golden(a, b);
    in_valid = v;
    in_a = a;
    in_b = b;
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin hv[k] = 1'b0; hp[k] = '0; end
    void'($urandom(32'd7041));
    // R1: quiet during reset, inputs toggling
    tag = "R1";
    for (int i = 0; i < 4; i++) step(1'b1, 16'h1234, 16'h5678);
    step(1'b0, 16'h0, 16'h0);
    rst_n = 1'b1;
    // R1: first edges after release stay quiet
    for (int i = 0; i < 3; i++) step(1'b0, 16'hffff, 16'hffff);
    // R8 R2: extreme operands back to back
    tag = "R8 R2";
    step(1'b1, 16'h8000, 16'h8000);
    step(1'b1, 16'h8000, 16'h7fff);
    step(1'b1, 16'h7fff, 16'h7fff);
    step(1'b1, 16'h7fff, 16'h8000);
    step(1'b1, 16'h0000, 16'h8000);
    step(1'b1, 16'hffff, 16'hffff);
    step(1'b1, 16'hffff, 16'h0001);
    step(1'b1, 16'h8000, 16'h0000);
    // R4 R6 R7: dense random stream, one pair every clock
    tag = "R4 R6 R7";
    for (int i = 0; i < 400; i++) step(1'b1, 16'($urandom), 16'($urandom));
    // R3 R5: random gaps between valid pairs
    tag = "R3 R5";
    for (int i = 0; i < 600; i++)
      step(($urandom % 5) < 3, 16'($urandom), 16'($urandom));
    // R5: single isolated pairs and odd-length gaps
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 16'($urandom), 16'($urandom));
      for (int g = 0; g < (i % 4) + 1; g++) step(1'b0, 16'($urandom), 16'($urandom));
    end
    // R3: drain
    tag = "R3";
    for (int i = 0; i < 6; i++) step(1'b0, 16'h0, 16'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule